// File: doc/BRIEF.md
# UART Channel Interrupt Status and Mask

This block holds the interrupt status of one UART channel in an 8-bit register. Six of its bits are latched flags. Each flag is set by a one-cycle strobe from its own event source. Each is cleared by the host action that belongs to that source: a read of a related register or a command write. The two lowest bits are not latched. They mirror the receive and transmit FIFO level requests as they stand in each cycle.

An 8-bit mask register selects which status bits may raise the active-low interrupt request. A configuration input chooses what a status read returns: the raw status, or the status ANDed with the mask. Arbitration between channels and the event sources themselves sit outside the block.

When an event strobe and the clear action for the same flag arrive in one cycle, the event is kept.

Top module: `uart_irq_status`

## Requirements
- R1: Status bit positions are: 7 input-pin change, 6 receive watchdog timeout, 5 address match, 4 flow-control character, 3 counter/timer ready, 2 break change. A strobe on a flag's event input sets that flag at the next clock edge. The set is visible on `stat_rdata` after that edge.
- R2: Bit 7 is cleared at the clock edge where `rd_inport` is high.
- R3: Bit 6 is cleared at the clock edge where `rd_rxfifo` is high.
- R4: Bit 5 is cleared only by a command write whose low 5 bits are 11011. Bits above bit 4 of the command are ignored. Any other command code leaves bit 5 set.
- R5: Bit 4 is cleared at the clock edge where `rd_xstat` is high.
- R6: Bit 3 is cleared by a command write whose low 5 bits are 01010 (counter stop).
- R7: Bit 2 is cleared by a command write whose low 5 bits are 00101 (break-change reset).
- R8: Status bit 1 equals `rx_lvl_req` and status bit 0 equals `tx_lvl_req` in the same cycle, with no register between them.
- R9: If a flag's event strobe and its clear action occur in the same cycle, the flag is 1 after that edge.
- R10: `irq_n` is 0 exactly when some status bit and its mask bit are both 1. A status bit whose mask bit is 0 has no effect on `irq_n`. A high `mask_wr` loads `mask_wdata` into the mask at the clock edge.
- R11: With `cfg_rd_mask` = 0, `stat_rdata` is the raw status. With `cfg_rd_mask` = 1, it is the status ANDed with the mask.
- R12: After a synchronous reset (`rst_n` low at a clock edge), all latched flags are 0 and the mask is 0. As a result, `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pin_chg | input | 1 | Strobe: general input pin changed state |
| evt_rx_wdog | input | 1 | Strobe: receive watchdog timed out |
| evt_addr_match | input | 1 | Strobe: received address matched the reference |
| evt_flow_char | input | 1 | Strobe: flow-control character received |
| evt_ct_ready | input | 1 | Strobe: counter/timer expired or crossed zero |
| evt_brk_chg | input | 1 | Strobe: break started or ended |
| rx_lvl_req | input | 1 | Receive FIFO level condition (level) |
| tx_lvl_req | input | 1 | Transmit FIFO level condition (level) |
| rd_inport | input | 1 | Host read of input port register |
| rd_rxfifo | input | 1 | Host read of receive FIFO |
| rd_xstat | input | 1 | Host read of flow-control status register |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | CMD_W | Command code; low 5 bits decoded |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| cfg_rd_mask | input | 1 | 1: status read returns status AND mask |
| stat_rdata | output | 8 | Status read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit command bus and the three default clear codes. The 8-bit bus puts nonzero upper command bits within reach, so the bench can check that only the low five bits are decoded. The default codes let it check that one clear command leaves the other flags untouched. It checks every flag with its event and its clear action in the same cycle. It also checks the interrupt output with a single mask bit enabled, and with the mask bit of a set flag held at zero.

// File: rtl/uart_irq_pkg.sv
// Package: shared bit positions and widths for the channel interrupt status block.
// Assumes an 8-bit status layout fixed by the host register map.
package uart_irq_pkg;
    localparam int STAT_W     = 8;
    localparam int CMD_DEC_W  = 5;
    localparam int LAT_LO     = 2;
    localparam int LAT_HI     = 7;
    localparam int LAT_N      = LAT_HI - LAT_LO + 1;

    localparam int B_PIN  = 7;
    localparam int B_WDOG = 6;
    localparam int B_ADDR = 5;
    localparam int B_FLOW = 4;
    localparam int B_CT   = 3;
    localparam int B_BRK  = 2;
    localparam int B_RXL  = 1;
    localparam int B_TXL  = 0;

    typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/uart_irq_cmd_dec.sv
// Module: decodes a host command write into one-cycle clear pulses.
// Assumes only the low CMD_DEC_W bits of the command carry the code.
module uart_irq_cmd_dec
    import uart_irq_pkg::*;
#(
    parameter int                 CMD_W        = 8,
    parameter logic [CMD_DEC_W-1:0] CODE_ADDR_RST = 5'b11011,
    parameter logic [CMD_DEC_W-1:0] CODE_CT_STOP  = 5'b01010,
    parameter logic [CMD_DEC_W-1:0] CODE_BRK_RST  = 5'b00101
) (
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             clr_addr,
    output logic             clr_ct,
    output logic             clr_brk
);
    logic [CMD_DEC_W-1:0] code_lo;

    // Extract the decoded field of the command.
    always_comb begin
        code_lo = cmd_code[CMD_DEC_W-1:0];
    end

    // Compare the field against each clear code while a write is present.
    always_comb begin
        clr_addr = cmd_wr && (code_lo == CODE_ADDR_RST);
        clr_ct   = cmd_wr && (code_lo == CODE_CT_STOP);
        clr_brk  = cmd_wr && (code_lo == CODE_BRK_RST);
    end
endmodule

// File: rtl/uart_irq_flag.sv
// Module: one latched status flag with set priority over clear.
// Assumes set and clear are single-cycle strobes in the clk domain.
module uart_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold the flag; an event in the clear cycle is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (set_i)  q <= 1'b1;
        else if (clr_i)  q <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_mask.sv
// Module: host-written interrupt mask register.
// Assumes a full-width write on each mask_wr strobe.
module uart_irq_mask #(
    parameter int            W       = 8,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    // Load new mask on write, return to reset value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   mask <= RST_VAL;
        else if (wr)  mask <= wdata;
    end
endmodule

// File: rtl/uart_irq_status.sv
// Module: per-channel UART interrupt status register with mask and request.
// Latched flags sit in bits 7..2; bits 1..0 mirror FIFO level requests.
// Assumes all strobes are synchronous to clk and one cycle wide.
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pin_chg,
    input  logic              evt_rx_wdog,
    input  logic              evt_addr_match,
    input  logic              evt_flow_char,
    input  logic              evt_ct_ready,
    input  logic              evt_brk_chg,
    input  logic              rx_lvl_req,
    input  logic              tx_lvl_req,
    input  logic              rd_inport,
    input  logic              rd_rxfifo,
    input  logic              rd_xstat,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              cfg_rd_mask,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq_n
);
    logic              clr_addr, clr_ct, clr_brk;
    logic [STAT_W-1:0] set_vec, clr_vec;
    stat_t             status;
    stat_t             mask;
    stat_t             active;

    uart_irq_cmd_dec #(.CMD_W(CMD_W)) u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_code (cmd_code),
        .clr_addr (clr_addr),
        .clr_ct   (clr_ct),
        .clr_brk  (clr_brk)
    );

    // Gather per-bit event and clear strobes into vectors by position.
    always_comb begin
        set_vec         = '0;
        clr_vec         = '0;
        set_vec[B_PIN]  = evt_pin_chg;    clr_vec[B_PIN]  = rd_inport;
        set_vec[B_WDOG] = evt_rx_wdog;    clr_vec[B_WDOG] = rd_rxfifo;
        set_vec[B_ADDR] = evt_addr_match; clr_vec[B_ADDR] = clr_addr;
        set_vec[B_FLOW] = evt_flow_char;  clr_vec[B_FLOW] = rd_xstat;
        set_vec[B_CT]   = evt_ct_ready;   clr_vec[B_CT]   = clr_ct;
        set_vec[B_BRK]  = evt_brk_chg;    clr_vec[B_BRK]  = clr_brk;
    end

    genvar gi;
    generate
        for (gi = LAT_LO; gi <= LAT_HI; gi++) begin : g_flag
            uart_irq_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[gi]),
                .clr_i (clr_vec[gi]),
                .q     (status[gi])
            );
        end
    endgenerate

    // Level-following bits track FIFO conditions directly.
    always_comb begin
        status[B_RXL] = rx_lvl_req;
        status[B_TXL] = tx_lvl_req;
    end

    uart_irq_mask #(.W(STAT_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mask_wr),
        .wdata (mask_wdata),
        .mask  (mask)
    );

    // Form the enabled sources, the request and the read data.
    always_comb begin
        active     = status & mask;
        irq_n      = ~(|active);
        stat_rdata = cfg_rd_mask ? active : status;
    end
endmodule

// File: rtl/uart_irq_status_chk.sv
// Checker: temporal properties of the status block, observed at its ports.
module uart_irq_status_chk #(
    parameter int CMD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_addr_match,
    input logic             evt_pin_chg,
    input logic             rd_inport,
    input logic             rx_lvl_req,
    input logic             tx_lvl_req,
    input logic             cmd_wr,
    input logic [CMD_W-1:0] cmd_code,
    input logic             cfg_rd_mask,
    input logic [7:0]       stat_rdata,
    input logic             irq_n
);
    a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_mask |-> (stat_rdata[1] == rx_lvl_req && stat_rdata[0] == tx_lvl_req));

    a_r10_irq_matches_masked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_mask |-> (irq_n == ~(|stat_rdata)));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rd_mask && $past(rst_n) && $past(evt_addr_match)) |-> stat_rdata[5]);

    a_r4_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rd_mask && $past(rst_n && !cfg_rd_mask && stat_rdata[5]
            && !(cmd_wr && cmd_code[4:0] == 5'b11011))) |-> stat_rdata[5]);

    a_r2_pin_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rd_mask && $past(rst_n && rd_inport && !evt_pin_chg)) |-> !stat_rdata[7]);

    a_r12_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !cfg_rd_mask) |-> (stat_rdata[7:2] == 6'b0 && irq_n));
endmodule

bind uart_irq_status uart_irq_status_chk #(.CMD_W(CMD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_addr_match (evt_addr_match),
    .evt_pin_chg    (evt_pin_chg),
    .rd_inport      (rd_inport),
    .rx_lvl_req     (rx_lvl_req),
    .tx_lvl_req     (tx_lvl_req),
    .cmd_wr         (cmd_wr),
    .cmd_code       (cmd_code),
    .cfg_rd_mask    (cfg_rd_mask),
    .stat_rdata     (stat_rdata),
    .irq_n          (irq_n)
);

// File: tb/uart_irq_status_tb.sv
module uart_irq_status_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_pin_chg, evt_rx_wdog, evt_addr_match, evt_flow_char, evt_ct_ready, evt_brk_chg;
    logic       rx_lvl_req, tx_lvl_req;
    logic       rd_inport, rd_rxfifo, rd_xstat;
    logic       cmd_wr;
    logic [7:0] cmd_code;
    logic       mask_wr;
    logic [7:0] mask_wdata;
    logic       cfg_rd_mask;
    logic [7:0] stat_rdata;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_irq_status u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_pin_chg(evt_pin_chg), .evt_rx_wdog(evt_rx_wdog), .evt_addr_match(evt_addr_match),
        .evt_flow_char(evt_flow_char), .evt_ct_ready(evt_ct_ready), .evt_brk_chg(evt_brk_chg),
        .rx_lvl_req(rx_lvl_req), .tx_lvl_req(tx_lvl_req),
        .rd_inport(rd_inport), .rd_rxfifo(rd_rxfifo), .rd_xstat(rd_xstat),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .cfg_rd_mask(cfg_rd_mask), .stat_rdata(stat_rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        evt_pin_chg = 0; evt_rx_wdog = 0; evt_addr_match = 0; evt_flow_char = 0;
        evt_ct_ready = 0; evt_brk_chg = 0; rd_inport = 0; rd_rxfifo = 0; rd_xstat = 0;
        cmd_wr = 0; cmd_code = 8'h00; mask_wr = 0; mask_wdata = 8'h00;
    endtask

    // Let one rising edge pass with the current drive, then return to idle at the falling edge.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_cmd(input logic [7:0] c);
        cmd_wr = 1; cmd_code = c; step();
    endtask

    task automatic set_all();
        evt_pin_chg = 1; evt_rx_wdog = 1; evt_addr_match = 1; evt_flow_char = 1;
        evt_ct_ready = 1; evt_brk_chg = 1; step();
    endtask

    task automatic t_reset();
        set_all();
        mask_wr = 1; mask_wdata = 8'hFF; step();
        rst_n = 0; step(); rst_n = 1;
        check("R12 status after reset", stat_rdata, 8'h00);
        check("R12 irq_n after reset", {7'b0, irq_n}, 8'h01);
        cfg_rd_mask = 1; rx_lvl_req = 1;
        check("R12 mask zero after reset", stat_rdata, 8'h00);
        cfg_rd_mask = 0; rx_lvl_req = 0;
    endtask

    task automatic t_layout();
        evt_pin_chg = 1;    step(); check("R1 pin change bit7", stat_rdata, 8'h80);
        evt_rx_wdog = 1;    step(); check("R1 watchdog bit6", stat_rdata, 8'hC0);
        evt_addr_match = 1; step(); check("R1 address bit5", stat_rdata, 8'hE0);
        evt_flow_char = 1;  step(); check("R1 flow char bit4", stat_rdata, 8'hF0);
        evt_ct_ready = 1;   step(); check("R1 counter bit3", stat_rdata, 8'hF8);
        evt_brk_chg = 1;    step(); check("R1 break bit2", stat_rdata, 8'hFC);
    endtask

    task automatic t_clears();
        rd_inport = 1; step(); check("R2 inport read clears bit7", stat_rdata, 8'h7C);
        rd_rxfifo = 1; step(); check("R3 fifo read clears bit6", stat_rdata, 8'h3C);
        do_cmd(8'h05);  check("R7 break cmd clears only bit2", stat_rdata, 8'h38);
        do_cmd(8'h0A);  check("R6 counter stop clears bit3", stat_rdata, 8'h30);
        do_cmd(8'h1A);  check("R4 other code keeps bit5", stat_rdata, 8'h30);
        cmd_code = 8'h1B; step(); check("R4 code without write keeps bit5", stat_rdata, 8'h30);
        do_cmd(8'hFB);  check("R4 upper bits ignored, bit5 cleared", stat_rdata, 8'h10);
        rd_xstat = 1; step(); check("R5 status read clears bit4", stat_rdata, 8'h00);
    endtask

    task automatic t_levels();
        rx_lvl_req = 1; #1 check("R8 rx level bit1", stat_rdata, 8'h02);
        tx_lvl_req = 1; #1 check("R8 both levels", stat_rdata, 8'h03);
        rx_lvl_req = 0; #1 check("R8 rx level drops", stat_rdata, 8'h01);
        tx_lvl_req = 0; #1 check("R8 tx level drops", stat_rdata, 8'h00);
    endtask

    task automatic t_set_wins();
        evt_pin_chg = 1; rd_inport = 1;
        evt_rx_wdog = 1; rd_rxfifo = 1;
        evt_flow_char = 1; rd_xstat = 1;
        step(); check("R9 read-cleared flags keep event", stat_rdata, 8'hD0);
        evt_addr_match = 1; cmd_wr = 1; cmd_code = 8'h1B; step();
        evt_ct_ready = 1;   cmd_wr = 1; cmd_code = 8'h0A; step();
        evt_brk_chg = 1;    cmd_wr = 1; cmd_code = 8'h05; step();
        check("R9 command-cleared flags keep event", stat_rdata, 8'hFC);
    endtask

    task automatic t_irq();
        // All latched flags are set from t_set_wins; mask still zero.
        check("R10 unmasked flags do not request", {7'b0, irq_n}, 8'h01);
        mask_wr = 1; mask_wdata = 8'h08; step();
        check("R10 enabled counter flag requests", {7'b0, irq_n}, 8'h00);
        do_cmd(8'h0A);
        check("R10 request drops when flag clears", {7'b0, irq_n}, 8'h01);
        mask_wr = 1; mask_wdata = 8'h01; step();
        check("R10 level bit idle no request", {7'b0, irq_n}, 8'h01);
        tx_lvl_req = 1; #1
        check("R10 level bit requests", {7'b0, irq_n}, 8'h00);
        tx_lvl_req = 0; #1;
    endtask

    task automatic t_rdmask();
        mask_wr = 1; mask_wdata = 8'hA2; step();
        rx_lvl_req = 1; #1
        check("R11 raw read", stat_rdata, 8'hF6);
        cfg_rd_mask = 1; #1
        check("R11 masked read", stat_rdata, 8'hA2);
        cfg_rd_mask = 0; rx_lvl_req = 0; #1;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0; rx_lvl_req = 0; tx_lvl_req = 0; cfg_rd_mask = 0;
        step(); step();
        rst_n = 1;
        t_reset();
        t_layout();
        t_clears();
        t_levels();
        t_set_wins();
        t_irq();
        t_rdmask();
        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule